// File: doc/BRIEF.md
# Battery Status Check Sequencer

This block is a small hardware sequencer that runs one check after power-up to learn whether a battery-backed memory kept its backup supply. A memory whose backup has failed is assumed to silently drop the first write it receives. The sequencer uses this behaviour to detect the failure. It reads one byte at a test address, writes the inverted byte to the same address, then reads it back. A read-back equal to the inverted byte shows a healthy battery, and the original byte is then written back. Any other read-back shows a weak battery, and the contents of the memory should be treated as suspect.

A single-cycle start pulse launches the check. The test address comes either from an input captured at start or from a fixed parameter, chosen at build time. Every memory access goes out as a request to a bus controller. The request is held until the controller returns a one-cycle completion strobe, so the timing of the memory bus stays outside this block. When the check finishes, the block raises a done pulse together with one of two status bits. The status bits stay valid until the next check is accepted.

Top module: `bat_check_seq`

## Requirements
- R1: During and after reset, `busy_o`, `done_o`, `req_o`, `bat_ok_o` and `bat_low_o` are all 0.
- R2: A start pulse accepted while idle captures `addr_i`. The first request is a read (`req_we_o`=0) at that captured address, and later changes on `addr_i` have no effect on the sequence.
- R3: The second request is a write (`req_we_o`=1) to the same address, and its data is the bitwise inverse of the first read's data.
- R4: The third request is a read of the same address.
- R5: If the third read returns exactly the inverse of the first read, a fourth request writes the original byte back to the address. The check then ends with `bat_ok_o`=1 and `bat_low_o`=0.
- R6: If the third read differs from that inverse, no further request is issued. The check ends with `bat_low_o`=1 and `bat_ok_o`=0, which marks the stored data as possibly corrupted.
- R7: Once `req_o` is raised, it stays high, and `req_addr_o`, `req_we_o` and `req_wdata_o` stay unchanged, until the cycle in which `req_done_i` is sampled high.
- R8: `busy_o` is 1 from the cycle after an accepted start through the cycle of `done_o`, and 0 afterwards. `done_o` is high for exactly one cycle per check.
- R9: A start pulse that arrives while `busy_o` is 1 is ignored. It adds no request, does not change the address and produces no extra `done_o`.
- R10: `bat_ok_o` and `bat_low_o` hold their value after `done_o` until the next accepted start, which clears both. At `done_o`, exactly one of the two is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | One-cycle pulse that starts a check |
| addr_i | input | ADDR_W | Test address, captured at start (when the fixed-address option is off) |
| req_o | output | 1 | Memory request valid |
| req_we_o | output | 1 | 1 = write request, 0 = read request |
| req_addr_o | output | ADDR_W | Request address |
| req_wdata_o | output | DATA_W | Write data |
| req_done_i | input | 1 | One-cycle completion strobe from the bus controller |
| req_rdata_i | input | DATA_W | Read data, valid together with `req_done_i` on a read |
| busy_o | output | 1 | Check in progress |
| done_o | output | 1 | One-cycle end-of-check pulse |
| bat_ok_o | output | 1 | Last check passed |
| bat_low_o | output | 1 | Last check failed: battery low, data suspect |

## Verification
The assertions rely on two properties of the bus controller:
- It asserts `req_done_i` only while `req_o` is high.
- It pulses `req_done_i` for exactly one cycle per request, so a completion strobe is never counted against the next request.

The bench memory model is built to honour both. It raises the strobe only on a pending request, after a chosen latency of zero to three cycles, and always drops it on the following cycle before it looks at the next request. The bench also drives `start_i` for one cycle only, so that every start pulse is a single event, whether it lands in the idle state or mid-sequence.

// File: rtl/bcs_pkg.sv
package bcs_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD_ORIG,
    ST_WR_INV,
    ST_RD_BACK,
    ST_WR_REST,
    ST_DONE
  } bcs_state_e;
endpackage

// File: rtl/bcs_addr_sel.sv
module bcs_addr_sel #(
  parameter int unsigned        ADDR_W     = 11,
  parameter bit                 FIXED_EN   = 1'b0,
  parameter logic [ADDR_W-1:0]  FIXED_ADDR = '0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [ADDR_W-1:0] addr_o
);
  generate
    if (FIXED_EN) begin : g_fixed
      assign addr_o = FIXED_ADDR;
    end else begin : g_latch
      logic [ADDR_W-1:0] addr_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)     addr_q <= '0;
        else if (load_i) addr_q <= addr_i;
      end
      assign addr_o = addr_q;
    end
  endgenerate
endmodule

// File: rtl/bcs_data_path.sv
module bcs_data_path #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cap_i,
  input  logic [DATA_W-1:0] rdata_i,
  output logic [DATA_W-1:0] orig_o,
  output logic [DATA_W-1:0] inv_o,
  output logic              match_o
);
  logic [DATA_W-1:0] orig_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    orig_q <= '0;
    else if (cap_i) orig_q <= rdata_i;
  end

  assign orig_o  = orig_q;
  assign inv_o   = ~orig_q;
  // read-back must equal the inverted byte bit for bit
  assign match_o = (rdata_i == inv_o);
endmodule

// File: rtl/bcs_ctrl.sv
module bcs_ctrl
  import bcs_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  logic       req_done_i,
  input  logic       match_i,
  output bcs_state_e state_o,
  output logic       load_o,
  output logic       cap_o,
  output logic       ok_o,
  output logic       low_o
);
  bcs_state_e state_q, state_d;
  logic       ok_q, low_q, ok_d, low_d;

  always_comb begin
    state_d = state_q;
    ok_d    = ok_q;
    low_d   = low_q;
    load_o  = 1'b0;
    cap_o   = 1'b0;
    unique case (state_q)
      ST_IDLE: if (start_i) begin
        load_o  = 1'b1;
        ok_d    = 1'b0;
        low_d   = 1'b0;
        state_d = ST_RD_ORIG;
      end
      ST_RD_ORIG: if (req_done_i) begin
        cap_o   = 1'b1;
        state_d = ST_WR_INV;
      end
      ST_WR_INV: if (req_done_i) state_d = ST_RD_BACK;
      ST_RD_BACK: if (req_done_i) begin
        if (match_i) state_d = ST_WR_REST;
        else begin
          low_d   = 1'b1;
          state_d = ST_DONE;
        end
      end
      ST_WR_REST: if (req_done_i) begin
        ok_d    = 1'b1;
        state_d = ST_DONE;
      end
      ST_DONE: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      ok_q    <= 1'b0;
      low_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      ok_q    <= ok_d;
      low_q   <= low_d;
    end
  end

  assign state_o = state_q;
  assign ok_o    = ok_q;
  assign low_o   = low_q;

  // R8
  done_one_cycle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_DONE) |=> (state_q == ST_IDLE));

  // R9
  no_restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q != ST_IDLE && state_q != ST_DONE) |=> (state_q != ST_IDLE));

  // R6
  low_no_restore_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_RD_BACK && req_done_i && !match_i) |=> (state_q == ST_DONE && low_q && !ok_q));

  // R5
  ok_after_restore_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_WR_REST && req_done_i) |=> (ok_q && !low_q));
endmodule

// File: rtl/bat_check_seq.sv
module bat_check_seq
  import bcs_pkg::*;
#(
  parameter int unsigned       ADDR_W     = 11,
  parameter int unsigned       DATA_W     = 8,
  parameter bit                FIXED_EN   = 1'b0,
  parameter logic [ADDR_W-1:0] FIXED_ADDR = '0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              req_o,
  output logic              req_we_o,
  output logic [ADDR_W-1:0] req_addr_o,
  output logic [DATA_W-1:0] req_wdata_o,
  input  logic              req_done_i,
  input  logic [DATA_W-1:0] req_rdata_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              bat_ok_o,
  output logic              bat_low_o
);
  bcs_state_e        state;
  logic              load, cap, match;
  logic [DATA_W-1:0] orig, inv;

  bcs_ctrl u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start_i),
    .req_done_i (req_done_i),
    .match_i    (match),
    .state_o    (state),
    .load_o     (load),
    .cap_o      (cap),
    .ok_o       (bat_ok_o),
    .low_o      (bat_low_o)
  );

  bcs_addr_sel #(
    .ADDR_W     (ADDR_W),
    .FIXED_EN   (FIXED_EN),
    .FIXED_ADDR (FIXED_ADDR)
  ) u_addr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (load),
    .addr_i (addr_i),
    .addr_o (req_addr_o)
  );

  bcs_data_path #(.DATA_W(DATA_W)) u_data (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .cap_i   (cap),
    .rdata_i (req_rdata_i),
    .orig_o  (orig),
    .inv_o   (inv),
    .match_o (match)
  );

  always_comb begin
    req_o       = 1'b0;
    req_we_o    = 1'b0;
    req_wdata_o = inv;
    unique case (state)
      ST_RD_ORIG, ST_RD_BACK: req_o = 1'b1;
      ST_WR_INV: begin
        req_o    = 1'b1;
        req_we_o = 1'b1;
      end
      ST_WR_REST: begin
        req_o       = 1'b1;
        req_we_o    = 1'b1;
        req_wdata_o = orig;
      end
      default: ;
    endcase
  end

  assign busy_o = (state != ST_IDLE);
  assign done_o = (state == ST_DONE);

  // R7
  req_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_o && !req_done_i) |=> (req_o && $stable(req_addr_o) && $stable(req_we_o) && $stable(req_wdata_o)));

  // R10
  status_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $onehot({bat_ok_o, bat_low_o}));

  // R10
  status_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !start_i) |=> ($stable(bat_ok_o) && $stable(bat_low_o)));

  // R1
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (!req_o && !done_o));
endmodule

// File: tb/bat_check_seq_tb_top.sv
`timescale 1ns/100ps
module bat_check_seq_tb_top;
  localparam int AW = 11;
  localparam int DW = 8;

  typedef struct {
    logic [AW-1:0] addr;
    logic [DW-1:0] orig;
    int            kind; // 0 good, 1 first write dropped, 2 first write partial
  } exp_t;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [AW-1:0] addr_in = '0;
  logic          req, we, rdone = 1'b0;
  logic [AW-1:0] raddr;
  logic [DW-1:0] wdata, rdata = '0;
  logic          busy, done, ok, low;

  int tests = 0;
  int fails = 0;

  logic [DW-1:0] mem [0:(1<<AW)-1];
  logic          op_we [0:7];
  logic [AW-1:0] op_addr [0:7];
  logic [DW-1:0] op_wd [0:7];
  int            op_n = 0;
  int            lat = 0;
  int            bad_kind = 0;
  bit            first_wr = 1'b0;
  int            cnt = 0;
  exp_t          sb_q[$];

  always #2.5 clk = ~clk;

  bat_check_seq dut_i (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .start_i     (start),
    .addr_i      (addr_in),
    .req_o       (req),
    .req_we_o    (we),
    .req_addr_o  (raddr),
    .req_wdata_o (wdata),
    .req_done_i  (rdone),
    .req_rdata_i (rdata),
    .busy_o      (busy),
    .done_o      (done),
    .bat_ok_o    (ok),
    .bat_low_o   (low)
  );

  task automatic chk(input bit cond, input string rq, input string what, input int act, input int exp);
    tests++;
    if (!cond) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
    end
  endtask

  // memory model: fixed latency, one-cycle done strobe
  initial begin
    forever begin
      @(negedge clk);
      if (!rst_n) begin
        rdone = 1'b0;
        cnt   = 0;
      end else if (rdone) begin
        rdone = 1'b0;
        cnt   = 0;
      end else if (req) begin
        if (cnt >= lat) begin
          if (op_n < 8) begin
            op_we[op_n]   = we;
            op_addr[op_n] = raddr;
            op_wd[op_n]   = wdata;
          end
          op_n++;
          if (we) begin
            if (first_wr && bad_kind == 1) ;
            else if (first_wr && bad_kind == 2) mem[raddr] = (wdata & 8'hF0) | (mem[raddr] & 8'h0F);
            else mem[raddr] = wdata;
            first_wr = 1'b0;
          end else begin
            rdata = mem[raddr];
          end
          rdone = 1'b1;
        end else begin
          cnt++;
        end
      end
    end
  end

  // monitor: pop expected item at each done pulse
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && done) begin
        if (sb_q.size() == 0) begin
          chk(1'b0, "R9", "unexpected done", 1, 0);
        end else begin
          exp_t e;
          bit   g;
          logic [DW-1:0] fin;
          e = sb_q.pop_front();
          g = (e.kind == 0);
          chk(ok == g, g ? "R5" : "R6", "bat_ok", ok, g);
          chk(low == !g, g ? "R5" : "R6", "bat_low", low, !g);
          chk(op_n == (g ? 4 : 3), g ? "R5" : "R6", "request count", op_n, g ? 4 : 3);
          chk(op_we[0] == 1'b0 && op_addr[0] == e.addr, "R2", "first read addr", op_addr[0], e.addr);
          chk(op_we[1] == 1'b1 && op_addr[1] == e.addr, "R3", "inverse write addr", op_addr[1], e.addr);
          chk(op_wd[1] == ~e.orig, "R3", "inverse write data", op_wd[1], ~e.orig);
          chk(op_we[2] == 1'b0 && op_addr[2] == e.addr, "R4", "read-back addr", op_addr[2], e.addr);
          if (g) begin
            chk(op_we[3] == 1'b1 && op_addr[3] == e.addr, "R5", "restore addr", op_addr[3], e.addr);
            chk(op_wd[3] == e.orig, "R5", "restore data", op_wd[3], e.orig);
          end
          fin = (e.kind == 2) ? ((~e.orig & 8'hF0) | (e.orig & 8'h0F)) : e.orig;
          chk(mem[e.addr] == fin, g ? "R5" : "R6", "final memory byte", mem[e.addr], fin);
        end
      end
    end
  end

  task automatic run_chk(input logic [AW-1:0] a, input logic [DW-1:0] v, input int kind,
                         input int l, input bit intr);
    exp_t e;
    bit   eok, elow;
    @(negedge clk);
    mem[a]   = v;
    lat      = l;
    bad_kind = kind;
    first_wr = 1'b1;
    op_n     = 0;
    e.addr = a; e.orig = v; e.kind = kind;
    sb_q.push_back(e);
    addr_in = a;
    start   = 1'b1;
    @(negedge clk);
    start   = 1'b0;
    addr_in = ~a;
    chk(busy == 1'b1, "R8", "busy after start", busy, 1);
    chk(ok == 1'b0 && low == 1'b0, "R10", "status cleared on start", {ok, low}, 0);
    if (intr) begin
      repeat (3) @(negedge clk);
      addr_in = a ^ 11'h155;
      start   = 1'b1;
      @(negedge clk);
      start   = 1'b0;
    end
    while (!done) @(negedge clk);
    chk(busy == 1'b1, "R8", "busy at done", busy, 1);
    eok  = (kind == 0);
    elow = !eok;
    @(negedge clk);
    chk(done == 1'b0, "R8", "done one cycle", done, 0);
    chk(busy == 1'b0, "R8", "idle after done", busy, 0);
    repeat (3) @(negedge clk);
    chk(ok == eok && low == elow, "R10", "status held", {ok, low}, {eok, elow});
    chk(req == 1'b0 && done == 1'b0, intr ? "R9" : "R8", "quiet after check", {req, done}, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(busy == 0 && done == 0 && req == 0 && ok == 0 && low == 0, "R1", "reset state",
        {busy, done, req, ok, low}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(busy == 0 && req == 0, "R1", "idle after reset", {busy, req}, 0);
    run_chk(11'h123, 8'hA5, 0, 0, 1'b0);
    run_chk(11'h000, 8'h00, 0, 2, 1'b0);
    run_chk(11'h7FF, 8'hFF, 0, 1, 1'b0);
    run_chk(11'h2C4, 8'h3C, 1, 0, 1'b0);
    run_chk(11'h555, 8'h5A, 2, 3, 1'b0);
    run_chk(11'h0F0, 8'h81, 0, 1, 1'b1); // R9
    run_chk(11'h3AA, 8'hFF, 1, 2, 1'b1); // R9
    run_chk(11'h011, 8'h7E, 0, 0, 1'b0);
    chk(sb_q.size() == 0, "R8", "pending checks", sb_q.size(), 0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    tests++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule